// File: doc/BRIEF.md
# Programmed SPI Command Shifter

This block issues one short serial flash command that software has assembled byte by byte: write enable, an erase, a status register write or a register read. Software writes up to six transmit bytes into a slot array, writes a bit count, and then sets the start bit in the command register. The engine then owns the serial pins. It holds chip select low for exactly the programmed number of bits and clocks them out most significant bit first, starting with the opcode in the top slot. It captures the returning data bits into a receive bank.

The start bit also serves as the busy flag. It reads back as 1 while the engine is working, and the engine clears it when chip select has been released. Software polls that bit and then reads the receive bytes. The newest byte is found at receive index 0. After an N-byte read, the first byte that arrived sits at index N-1.

Top module: `spi_prog_shifter`

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, the command register reads 0x00 and every receive byte reads 0x00.
- R2: Writing a byte with bit 2 set to the command register (word address 0) while idle starts a transfer. Bit 2 reads 1 from the next cycle until the transfer ends and then reads 0. All other command bits always read 0, and a command write with bit 2 clear starts nothing.
- R3: MOSI carries exactly `count` bits, MSB first. They come from transmit slot 5 (address 7), then slot 4, and so on down to slot 0 (address 2). Zeros follow once all 48 slot bits have gone out.
- R4: SPI mode 0 is used. SCLK idles low and runs at the system clock divided by 4, and it toggles only while chip select is low. MOSI changes only at falling SCLK edges, and MISO is sampled on rising SCLK edges.
- R5: Chip select stays low for exactly 4*count+4 system clock cycles. That is the programmed bits plus one SCLK period after the last falling edge.
- R6: The receive bank is cleared when a transfer starts. The last bit received ends up in bit 0 of receive byte 0 (address 8), and receive byte k is at address 8+k. After an N-byte read, the first byte received is at index N-1.
- R7: A count of 0, or a count above 64, ends the command within two cycles. Chip select is never asserted and no SCLK edge is produced.
- R8: Any write to the command register while a transfer is in progress is ignored. The running transfer keeps its length, its data and its chip select timing.
- R9: The count register (address 1) and the transmit slots read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register byte write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte (combinational on address) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench targets the length limits: 1 bit, 8 bits (opcode only), 64 bits (every slot plus zero padding), and the rejected counts 0, 65 and 200. A design with an off-by-one bit counter shows up as one SCLK edge too many or too few and a wrong chip select width. A design that fails to reject bad counts pulses chip select. A bench slave returns a random response, so a reversed receive byte order or a wrong sampling edge produces shifted or swapped receive bytes. Command writes made mid-transfer expose an engine that restarts or aborts, because the transfer length and the captured data would then change.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;
   localparam int CMD_START_BIT = 2;
   localparam int CMD_ADDR      = 0;
   localparam int CNT_ADDR      = 1;
   localparam int TX_BASE       = 2;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_SHIFT = 2'd1,
      ENG_TAIL  = 2'd2
   } eng_state_t;
endpackage

// File: rtl/spi_prog_divider.sv
module spi_prog_divider #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic rise_now,
   output logic fall_now
);
   localparam int HALF = DIV / 2;
   localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;

   if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
      $error("spi_prog_divider: DIV must be even and at least 2");
   end

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (!run || phase_q == PH_W'(DIV - 1))
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end

   assign rise_now = run && (phase_q == PH_W'(HALF - 1));
   assign fall_now = run && (phase_q == PH_W'(DIV - 1));
endmodule

// File: rtl/spi_prog_regs.sv
module spi_prog_regs
   import spi_prog_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int TX_SLOTS = 6,
   parameter int RX_SLOTS = 8,
   parameter int CNT_W    = 8,
   parameter int ADDR_W   = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [BYTE_W-1:0]            wdata,
   output logic [BYTE_W-1:0]            rdata,
   input  logic                         done,
   input  logic [RX_SLOTS*BYTE_W-1:0]   rx_bank,
   output logic [TX_SLOTS*BYTE_W-1:0]   tx_bank,
   output logic [CNT_W-1:0]             cnt,
   output logic                         busy,
   output logic                         start
);
   localparam int RX_BASE = TX_BASE + TX_SLOTS;

   if (CNT_W > BYTE_W) begin : g_bad_cnt
      $error("spi_prog_regs: count register wider than a byte");
   end
   if (CMD_START_BIT >= BYTE_W) begin : g_bad_bit
      $error("spi_prog_regs: start bit outside the byte");
   end

   logic cmd_hit;
   assign cmd_hit = wr_en && (addr == ADDR_W'(CMD_ADDR));
   assign start   = cmd_hit && wdata[CMD_START_BIT] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else begin
         if (start)
            busy <= 1'b1;
         else if (done)
            busy <= 1'b0;
         if (wr_en && addr == ADDR_W'(CNT_ADDR))
            cnt <= wdata[CNT_W-1:0];
      end
   end

   for (genvar s = 0; s < TX_SLOTS; s++) begin : g_tx_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tx_bank[s*BYTE_W +: BYTE_W] <= '0;
         else if (wr_en && addr == ADDR_W'(TX_BASE + s))
            tx_bank[s*BYTE_W +: BYTE_W] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(CMD_ADDR))
         rdata[CMD_START_BIT] = busy;
      if (addr == ADDR_W'(CNT_ADDR))
         rdata = BYTE_W'(cnt);
      for (int s = 0; s < TX_SLOTS; s++)
         if (addr == ADDR_W'(TX_BASE + s))
            rdata = tx_bank[s*BYTE_W +: BYTE_W];
      for (int r = 0; r < RX_SLOTS; r++)
         if (addr == ADDR_W'(RX_BASE + r))
            rdata = rx_bank[r*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/spi_prog_engine.sv
module spi_prog_engine
   import spi_prog_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int TX_SLOTS = 6,
   parameter int RX_SLOTS = 8,
   parameter int CNT_W    = 8,
   parameter int DIV      = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [CNT_W-1:0]             cnt,
   input  logic [TX_SLOTS*BYTE_W-1:0]   tx_bank,
   output logic [RX_SLOTS*BYTE_W-1:0]   rx_bank,
   output logic                         done,
   output logic                         cs_n,
   output logic                         sclk,
   output logic                         mosi,
   input  logic                         miso
);
   localparam int SR_W    = RX_SLOTS * BYTE_W;
   localparam int TX_BITS = TX_SLOTS * BYTE_W;
   localparam int BIT_W   = $clog2(SR_W + 1);

   if (SR_W < TX_BITS) begin : g_bad_sr
      $error("spi_prog_engine: receive bank smaller than transmit slots");
   end
   if ((2 ** CNT_W) <= SR_W) begin : g_bad_cntw
      $error("spi_prog_engine: count register cannot hold the maximum length");
   end

   eng_state_t       state_q;
   logic [SR_W-1:0]  txsr_q, rxsr_q, tx_load;
   logic [BIT_W-1:0] bits_q, last_q;
   logic             cnt_ok, rise_now, fall_now;

   if (SR_W > TX_BITS) begin : g_pad
      assign tx_load = {tx_bank, {(SR_W - TX_BITS){1'b0}}};
   end else begin : g_nopad
      assign tx_load = tx_bank;
   end

   assign cnt_ok = (cnt != '0) && (cnt <= CNT_W'(SR_W));

   spi_prog_divider #(.DIV(DIV)) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state_q != ENG_IDLE),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         cs_n    <= 1'b1;
         sclk    <= 1'b0;
         done    <= 1'b0;
         bits_q  <= '0;
         last_q  <= '0;
         txsr_q  <= '0;
         rxsr_q  <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ENG_IDLE: begin
               if (start) begin
                  if (cnt_ok) begin
                     state_q <= ENG_SHIFT;
                     cs_n    <= 1'b0;
                     bits_q  <= '0;
                     last_q  <= BIT_W'(cnt - 1'b1);
                     txsr_q  <= tx_load;
                     rxsr_q  <= '0;
                  end else begin
                     done <= 1'b1;
                  end
               end
            end
            ENG_SHIFT: begin
               if (rise_now) begin
                  sclk   <= 1'b1;
                  rxsr_q <= {rxsr_q[SR_W-2:0], miso};
               end
               if (fall_now) begin
                  sclk <= 1'b0;
                  if (bits_q == last_q) begin
                     state_q <= ENG_TAIL;
                  end else begin
                     bits_q <= bits_q + 1'b1;
                     txsr_q <= {txsr_q[SR_W-2:0], 1'b0};
                  end
               end
            end
            ENG_TAIL: begin
               if (fall_now) begin
                  state_q <= ENG_IDLE;
                  cs_n    <= 1'b1;
                  done    <= 1'b1;
               end
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   assign mosi    = !cs_n && txsr_q[SR_W-1];
   assign rx_bank = rxsr_q;
endmodule

// File: rtl/spi_prog_shifter.sv
module spi_prog_shifter #(
   parameter int BYTE_W   = 8,
   parameter int TX_SLOTS = 6,
   parameter int RX_SLOTS = 8,
   parameter int CNT_W    = 8,
   parameter int DIV      = 4,
   parameter int ADDR_W   = $clog2(2 + TX_SLOTS + RX_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   output logic              spi_cs_n,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   if ((2 ** ADDR_W) < 2 + TX_SLOTS + RX_SLOTS) begin : g_bad_addr
      $error("spi_prog_shifter: address too narrow for register map");
   end

   logic [TX_SLOTS*BYTE_W-1:0] tx_bank;
   logic [RX_SLOTS*BYTE_W-1:0] rx_bank;
   logic [CNT_W-1:0]           count_q;
   logic                       busy_q, start, done;

   spi_prog_regs #(
      .BYTE_W(BYTE_W), .TX_SLOTS(TX_SLOTS), .RX_SLOTS(RX_SLOTS),
      .CNT_W(CNT_W), .ADDR_W(ADDR_W)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .done    (done),
      .rx_bank (rx_bank),
      .tx_bank (tx_bank),
      .cnt     (count_q),
      .busy    (busy_q),
      .start   (start)
   );

   spi_prog_engine #(
      .BYTE_W(BYTE_W), .TX_SLOTS(TX_SLOTS), .RX_SLOTS(RX_SLOTS),
      .CNT_W(CNT_W), .DIV(DIV)
   ) eng_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .cnt     (count_q),
      .tx_bank (tx_bank),
      .rx_bank (rx_bank),
      .done    (done),
      .cs_n    (spi_cs_n),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi),
      .miso    (spi_miso)
   );
endmodule

// File: rtl/spi_prog_shifter_chk.sv
module spi_prog_shifter_chk #(
   parameter int CNT_W   = 8,
   parameter int MAXBITS = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             sclk,
   input logic             mosi,
   input logic             busy,
   input logic [CNT_W-1:0] cnt
);
   // R4
   sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R4
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n) && !$fell(sclk)) |-> $stable(mosi));

   // R2
   select_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   // R7
   legal_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (cnt != '0 && cnt <= CNT_W'(MAXBITS)));

   // R2
   busy_ends_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> cs_n);
endmodule

bind spi_prog_shifter spi_prog_shifter_chk #(
   .CNT_W(CNT_W), .MAXBITS(RX_SLOTS * BYTE_W)
) chk_i (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_n  (spi_cs_n),
   .sclk  (spi_sclk),
   .mosi  (spi_mosi),
   .busy  (busy_q),
   .cnt   (count_q)
);

// File: tb/spi_prog_shifter_tb_top.sv
module spi_prog_shifter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       cs_n, sclk, mosi;
   logic       miso = 1'b0;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   spi_prog_shifter dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .spi_cs_n(cs_n),
      .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso)
   );

   // bench-side flash model and monitors
   logic [63:0] resp = '0;
   logic [63:0] mosi_log = '0;
   int          sl_idx = 63;
   int          rises = 0;
   int          cs_cycles = 0;

   always @(negedge cs_n) begin
      sl_idx = 63;
      miso   = resp[63];
   end
   always @(negedge sclk) begin
      if (!cs_n) begin
         sl_idx = sl_idx - 1;
         miso   = (sl_idx >= 0) ? resp[sl_idx] : 1'b0;
      end
   end
   always @(posedge sclk) begin
      mosi_log = {mosi_log[62:0], mosi};
      rises    = rises + 1;
   end
   always @(negedge clk) if (!cs_n) cs_cycles = cs_cycles + 1;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   function automatic logic [63:0] expect_mosi(input logic [47:0] txv, input int n);
      logic [63:0] full = {txv, 16'h0};
      return full >> (64 - n);
   endfunction

   function automatic logic [63:0] expect_rx(input logic [63:0] r, input int n);
      return r >> (64 - n);
   endfunction

   task automatic run_xfer(input logic [47:0] txv, input int n, input logic [63:0] r,
                           input bit poke);
      logic [7:0]  d;
      logic [63:0] erx;
      int          polls;
      for (int s = 0; s < 6; s++) reg_write(4'(2 + s), txv[s*8 +: 8]);
      reg_write(4'd1, 8'(n));
      resp = r; mosi_log = '0; rises = 0; cs_cycles = 0;
      reg_write(4'd0, 8'h04);
      reg_read(4'd0, d);
      check(d == 8'h04, "R2 busy set after start", 64'(d), 64'h04);
      if (poke) begin
         repeat (5) @(negedge clk);
         reg_write(4'd0, 8'h04); // R8
         reg_write(4'd0, 8'h00); // R8
      end
      polls = 0;
      do begin
         reg_read(4'd0, d);
         polls++;
      end while (d[2] && polls < 2000);
      check(d == 8'h00, "R2 busy cleared", 64'(d), 64'h0);
      if (n == 0 || n > 64) begin
         check(polls <= 2, "R7 quick completion", 64'(polls), 64'd2);
         check(cs_cycles == 0, "R7 no chip select", 64'(cs_cycles), 64'd0);
         check(rises == 0, "R7 no sclk", 64'(rises), 64'd0);
      end else begin
         check(rises == n, "R3 bit count", 64'(rises), 64'(n));
         check(mosi_log == expect_mosi(txv, n), "R3 mosi data",
               mosi_log, expect_mosi(txv, n));
         check(cs_cycles == 4 * n + 4, poke ? "R8 cs width under poke" : "R5 cs width",
               64'(cs_cycles), 64'(4 * n + 4));
         erx = expect_rx(r, n);
         for (int k = 0; k < 8; k++) begin
            reg_read(4'(8 + k), d);
            check(d == erx[k*8 +: 8], "R6 rx byte", 64'(d), 64'(erx[k*8 +: 8]));
         end
      end
      check(cs_n && !sclk && !mosi, "R4 idle pins", {61'd0, cs_n, sclk, mosi}, 64'h4);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : main
      logic [7:0]  d;
      logic [47:0] txv;
      logic [63:0] r;
      int          n;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check(cs_n && !sclk && !mosi, "R1 reset pins", {61'd0, cs_n, sclk, mosi}, 64'h4);
      reg_read(4'd0, d);
      check(d == 8'h00, "R1 command reset", 64'(d), 64'h0);
      rst_n = 1'b1;
      reg_read(4'd8, d);
      check(d == 8'h00, "R1 rx reset", 64'(d), 64'h0);
      for (int k = 0; k < 8; k++) begin
         reg_read(4'(8 + k), d);
         check(d == 8'h00, "R1 rx bank reset", 64'(d), 64'h0);
      end

      // R2: other command bits read 0 and start nothing
      cs_cycles = 0;
      reg_write(4'd1, 8'd8);
      reg_write(4'd0, 8'hFB);
      repeat (6) @(negedge clk);
      reg_read(4'd0, d);
      check(d == 8'h00, "R2 no start without bit 2", 64'(d), 64'h0);
      check(cs_cycles == 0, "R2 no chip select", 64'(cs_cycles), 64'd0);

      // R9 readback
      reg_write(4'd1, 8'd37);
      reg_read(4'd1, d);
      check(d == 8'd37, "R9 count readback", 64'(d), 64'd37);
      reg_write(4'd5, 8'hA6);
      reg_read(4'd5, d);
      check(d == 8'hA6, "R9 slot readback", 64'(d), 64'hA6);

      // directed corners
      run_xfer(48'h06_00_00_00_00_00, 8, 64'hFFFF_0000_1234_5678, 1'b0);
      run_xfer(48'h9F_11_22_33_44_55, 64, 64'h0123_4567_89AB_CDEF, 1'b0);
      run_xfer(48'h80_00_00_00_00_00, 1, 64'h8000_0000_0000_0000, 1'b0);
      run_xfer(48'h05_00_00_00_00_00, 16, 64'hC35A_0000_0000_0000, 1'b1);
      run_xfer(48'hD8_12_34_56_00_00, 0, 64'h0, 1'b0);
      run_xfer(48'hD8_12_34_56_00_00, 65, 64'h0, 1'b0);
      run_xfer(48'hD8_12_34_56_00_00, 200, 64'h0, 1'b0);

      // random traffic
      for (int it = 0; it < 24; it++) begin
         txv = {16'($urandom), $urandom};
         r   = {$urandom, $urandom};
         n   = (it % 2 == 0) ? 8 * (1 + int'($urandom % 8)) : 1 + int'($urandom % 64);
         run_xfer(txv, n, r, (it % 3) == 0);
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule